// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers interrupt events from the channel engines of an eight-channel DMA controller. Each channel can raise three classes of event: a transfer finishing its programmed count, an abort completing, and a bus or configuration error. Every event sets one sticky flag in a single status word, with one byte lane per class. Software reads that word and clears flags by writing ones. Each channel's control word carries one mask bit per class. The mask keeps the class away from the combined interrupt line but does not stop the flag from being recorded.

The same register port also accepts abort commands. A write to the abort command offset produces a one-cycle abort request for every channel whose bit is set, and the channel engines act on that request. The combined interrupt line is a registered OR of every flag whose mask is clear. The data-moving engines, the bus fabric and the interrupt controller are outside this block.

Top module: `dma_irq_status_unit`

## Requirements
- R1: After reset the status word reads 0, the interrupt output is 0 and the abort request vector is 0.
- R2: The status word holds error flags for channels 0..7 in bits [7:0], abort flags in bits [15:8] and terminal-count flags in bits [23:16]. An event pulse for channel n sets its flag at the next clock edge, and the flag stays set until it is cleared.
- R3: A write to offset 0x30 clears each status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write of 24'hFFFFFF to offset 0x30 clears every flag at once. A write of 24'h010101 shifted left by n clears exactly the three flags of channel n.
- R6: A write to offset 0x24 with bit n set drives abort request bit n high for exactly the one cycle after the write edge. A write to 0x24 does not change the status word.
- R7: Per-channel mask bits (control-word bit 1 for terminal count, bit 2 for error, bit 3 for abort) keep a set flag off the interrupt output without stopping the flag from being set. The interrupt output equals, one clock later, the OR of all set flags whose mask bit is 0.
- R8: A read at offset 0x30 returns the status word. A read at any other offset returns 0. Writes to any offset other than 0x30 and 0x24 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_err_i | input | 8 | Per-channel error event pulses |
| evt_abt_i | input | 8 | Per-channel abort-done event pulses |
| evt_tc_i | input | 8 | Per-channel terminal-count event pulses |
| mask_err_i | input | 8 | Per-channel error mask (control bit 2) |
| mask_abt_i | input | 8 | Per-channel abort mask (control bit 3) |
| mask_tc_i | input | 8 | Per-channel terminal-count mask (control bit 1) |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for reg_addr |
| abort_req_o | output | 8 | One-cycle per-channel abort requests |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The stimulus table steps through event pulses that land in each byte lane alone and in combination, so a misplaced lane shows up as a wrong bit. It then applies clearing writes of all zeros, of a single-channel pattern, of a bit that is not set and of all ones. These writes separate a write-one-to-clear register from a plain overwrite, and a per-channel clear from a per-class clear. Some writes coincide with events on the same bit or on other bits, which shows whether the set takes priority. Other writes go to the abort offset and to an unused offset, which shows the register decode and the length of the abort pulse. Directed mask tests set flags while they are masked and then unmask them, which separates gating of the interrupt from gating of the recorded flag. They also check that the interrupt drops one cycle later than the status word.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    // Event classes in lane order within the status word
    typedef enum logic [1:0] {
        CLS_ERR = 2'd0,
        CLS_ABT = 2'd1,
        CLS_TC  = 2'd2
    } evt_cls_e;

    localparam int unsigned NUM_CLS = 3;
endpackage

// File: rtl/dirq_flag_lane.sv
module dirq_flag_lane #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a pending set outranks a same-cycle clear
        st_d.flag = (st_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/dirq_reg_port.sv
module dirq_reg_port #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned N        = 8,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h30,
    parameter logic [ADDR_W-1:0] ABT_OFF  = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] clr_o,
    output logic [N-1:0]      abt_req_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [N-1:0] abt;
    } port_st_t;

    port_st_t st_d, st_q;
    logic hit_stat, hit_abt;

    always_comb begin
        hit_stat = (addr_i == STAT_OFF);
        hit_abt  = (addr_i == ABT_OFF);
        st_d     = st_q;
        // abort requests live for one cycle only
        st_d.abt = (wen_i && hit_abt) ? wdata_i[N-1:0] : '0;
        clr_o    = (wen_i && hit_stat) ? wdata_i : '0;
        rdata_o  = hit_stat ? status_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign abt_req_o = st_q.abt;

    p_abort_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_i && addr_i == ABT_OFF) |=> (abt_req_o == '0));

    p_abort_follows_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && addr_i == ABT_OFF) |=> (abt_req_o == $past(wdata_i[N-1:0])));
endmodule

// File: rtl/dirq_irq_merge.sv
module dirq_irq_merge #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(flags_i & ~mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i == '0) |=> !irq_o);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '1) |=> !irq_o);
endmodule

// File: rtl/dma_irq_status_unit.sv
module dma_irq_status_unit #(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFF = 'h30,
    parameter logic [ADDR_W-1:0] ABT_OFF  = 'h24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              evt_err_i,
    input  logic [NUM_CH-1:0]              evt_abt_i,
    input  logic [NUM_CH-1:0]              evt_tc_i,
    input  logic [NUM_CH-1:0]              mask_err_i,
    input  logic [NUM_CH-1:0]              mask_abt_i,
    input  logic [NUM_CH-1:0]              mask_tc_i,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_wen,
    input  logic [dirq_pkg::NUM_CLS*NUM_CH-1:0] reg_wdata,
    output logic [dirq_pkg::NUM_CLS*NUM_CH-1:0] reg_rdata,
    output logic [NUM_CH-1:0]              abort_req_o,
    output logic                           irq_o
);
    import dirq_pkg::*;

    localparam int unsigned LANE_W = NUM_CH;
    localparam int unsigned STAT_W = NUM_CLS * LANE_W;

    logic [NUM_CH-1:0] set_v  [NUM_CLS];
    logic [NUM_CH-1:0] mask_v [NUM_CLS];
    logic [NUM_CH-1:0] flag_v [NUM_CLS];
    logic [STAT_W-1:0] status_w, mask_w, clr_w;

    always_comb begin
        set_v[int'(CLS_ERR)]  = evt_err_i;
        set_v[int'(CLS_ABT)]  = evt_abt_i;
        set_v[int'(CLS_TC)]   = evt_tc_i;
        mask_v[int'(CLS_ERR)] = mask_err_i;
        mask_v[int'(CLS_ABT)] = mask_abt_i;
        mask_v[int'(CLS_TC)]  = mask_tc_i;
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_lane
        dirq_flag_lane #(.N(NUM_CH)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[c]),
            .clr_i  (clr_w[c*LANE_W +: LANE_W]),
            .flag_o (flag_v[c])
        );
        assign status_w[c*LANE_W +: LANE_W] = flag_v[c];
        assign mask_w[c*LANE_W +: LANE_W]   = mask_v[c];
    end

    dirq_reg_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (STAT_W),
        .N        (NUM_CH),
        .STAT_OFF (STAT_OFF),
        .ABT_OFF  (ABT_OFF)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr),
        .wen_i     (reg_wen),
        .wdata_i   (reg_wdata),
        .status_i  (status_w),
        .clr_o     (clr_w),
        .abt_req_o (abort_req_o),
        .rdata_o   (reg_rdata)
    );

    dirq_irq_merge #(.W(STAT_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (status_w),
        .mask_i  (mask_w),
        .irq_o   (irq_o)
    );

    p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == STAT_OFF && reg_wdata == '1 &&
         evt_err_i == '0 && evt_abt_i == '0 && evt_tc_i == '0)
        |=> (status_w == '0));

    p_abort_keeps_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == ABT_OFF &&
         evt_err_i == '0 && evt_abt_i == '0 && evt_tc_i == '0)
        |=> $stable(status_w));

    p_other_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != STAT_OFF) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_dma_irq_status_unit.sv
module tb_dma_irq_status_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  evt_err, evt_abt, evt_tc;
    logic [7:0]  m_err, m_abt, m_tc;
    logic [7:0]  addr;
    logic        wen;
    logic [23:0] wdata, rdata;
    logic [7:0]  abt_req;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_status_unit dut (
        .clk(clk), .rst_n(rst_n),
        .evt_err_i(evt_err), .evt_abt_i(evt_abt), .evt_tc_i(evt_tc),
        .mask_err_i(m_err), .mask_abt_i(m_abt), .mask_tc_i(m_tc),
        .reg_addr(addr), .reg_wen(wen), .reg_wdata(wdata),
        .reg_rdata(rdata), .abort_req_o(abt_req), .irq_o(irq)
    );

    typedef struct packed {
        logic [7:0]  err;
        logic [7:0]  abt;
        logic [7:0]  tc;
        logic        we;
        logic [7:0]  ad;
        logic [23:0] wd;
        logic [23:0] exp_stat;
        logic [7:0]  exp_abt;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{8'h01, 8'h00, 8'h00, 1'b0, 8'h30, 24'h000000, 24'h000001, 8'h00}, // R2 err lane
        '{8'h00, 8'h80, 8'h04, 1'b0, 8'h30, 24'h000000, 24'h048001, 8'h00}, // R2 abt+tc lanes
        '{8'h00, 8'h00, 8'hFF, 1'b0, 8'h30, 24'h000000, 24'hFF8001, 8'h00}, // R2 all tc
        '{8'h00, 8'h00, 8'h00, 1'b1, 8'h30, 24'h000000, 24'hFF8001, 8'h00}, // R3 zeros keep
        '{8'h00, 8'h00, 8'h00, 1'b1, 8'h30, 24'h040404, 24'hFB8001, 8'h00}, // R5 channel 2
        '{8'h01, 8'h00, 8'h00, 1'b1, 8'h30, 24'h000001, 24'hFB8001, 8'h00}, // R4 set wins
        '{8'h00, 8'h00, 8'h00, 1'b1, 8'h24, 24'h0000A5, 24'hFB8001, 8'hA5}, // R6 abort cmd
        '{8'h00, 8'h00, 8'h00, 1'b0, 8'h30, 24'h000000, 24'hFB8001, 8'h00}, // R6 pulse ends
        '{8'h00, 8'h00, 8'h00, 1'b1, 8'h30, 24'hFFFFFF, 24'h000000, 8'h00}, // R5 clear all
        '{8'h10, 8'h00, 8'h00, 1'b0, 8'h30, 24'h000000, 24'h000010, 8'h00}, // R2 err ch4
        '{8'h00, 8'h00, 8'h00, 1'b1, 8'h20, 24'hFFFFFF, 24'h000010, 8'h00}, // R8 other offset
        '{8'h00, 8'h02, 8'h00, 1'b1, 8'h30, 24'h800000, 24'h000210, 8'h00}, // R3 clear unset bit
        '{8'h00, 8'h00, 8'h00, 1'b1, 8'h30, 24'hFFFFFF, 24'h000000, 8'h00}  // R5 clear all
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        evt_err = '0; evt_abt = '0; evt_tc = '0;
        wen = 1'b0; addr = 8'h30; wdata = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        quiet();
        m_err = '0; m_abt = '0; m_tc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 status", {8'h0, rdata}, 32'h0);
        chk("R1 abort", {24'h0, abt_req}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            evt_err = VECS[i].err; evt_abt = VECS[i].abt; evt_tc = VECS[i].tc;
            wen = VECS[i].we; addr = VECS[i].ad; wdata = VECS[i].wd;
            @(negedge clk);
            quiet();
            #1;
            chk($sformatf("R2/R3/R4/R5 vector %0d status", i), {8'h0, rdata}, {8'h0, VECS[i].exp_stat});
            chk($sformatf("R6 vector %0d abort", i), {24'h0, abt_req}, {24'h0, VECS[i].exp_abt});
        end

        // R8: read decode
        @(negedge clk);
        evt_err = 8'h20;
        @(negedge clk);
        quiet();
        addr = 8'h24;
        #1;
        chk("R8 read abort offset", {8'h0, rdata}, 32'h0);
        addr = 8'h30;
        #1;
        chk("R2 err ch5", {8'h0, rdata}, 32'h000020);

        // R7: masking gates irq only
        m_err = '1; m_abt = '1; m_tc = '1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R7 masked irq low", {31'h0, irq}, 32'h0);
        chk("R7 masked flag kept", {8'h0, rdata}, 32'h000020);
        evt_tc = 8'h01;
        @(negedge clk);
        evt_tc = 8'h00;
        @(negedge clk);
        #1;
        chk("R7 set while masked", {8'h0, rdata}, 32'h010020);
        chk("R7 still masked irq", {31'h0, irq}, 32'h0);
        m_tc = 8'hFE;
        @(negedge clk);
        #1;
        chk("R7 unmask tc0 irq", {31'h0, irq}, 32'h1);
        wen = 1'b1; wdata = 24'h010000;
        @(negedge clk);
        quiet();
        #1;
        chk("R7 irq lags clear", {31'h0, irq}, 32'h1);
        chk("R3 tc0 cleared", {8'h0, rdata}, 32'h000020);
        @(negedge clk);
        #1;
        chk("R7 irq drops", {31'h0, irq}, 32'h0);
        m_err = 8'hDF;
        @(negedge clk);
        #1;
        chk("R7 unmask err5 irq", {31'h0, irq}, 32'h1);
        wen = 1'b1; wdata = 24'hFFFFFF;
        @(negedge clk);
        quiet();
        @(negedge clk);
        #1;
        chk("R5 clear all status", {8'h0, rdata}, 32'h0);
        chk("R7 irq after clear all", {31'h0, irq}, 32'h0);

        summary();
        $finish;
    end
endmodule